// File: doc/BRIEF.md
# Address Table Command Engine

This block holds a small MAC forwarding table of 16 entries and runs commands on it from a register interface. Software first stages one entry across three 32-bit data words: the MAC address, a 7-bit port mask, a 12-bit VLAN ID and a 4-bit status. It then writes a function register with its busy bit set, a command code, and an optional port filter. The engine walks the table one slot per cycle. It then commits the result and clears busy.

Four commands are supported. Load adds or updates an entry and raises a full flag when no slot is free. Purge deletes the entry with a matching key. Flush empties the table. Next is an iterator: it returns the entry that follows the staged key, and writes it back into the data words. Software reads the whole table by feeding each result back in as the next key, until an empty status comes back.

Top module: `addr_table_engine`

## Requirements
- R1: After reset all four registers read zero and the table holds no valid entry.
- R2: Word 0 (address 0) holds MAC bits [31:0]. Word 1 (address 1) holds MAC bits [47:32] in [15:0] and the port mask in [22:16]. Word 2 (address 2) holds the status in [3:0] and the VLAN ID in [19:8]. The function register (address 3) holds the command in [3:0], the filter port in [10:8], the filter enable in [12], full in [30] and busy in [31]. All other bits read zero. A status of 0 means an empty entry, and 15 is the value software uses for static entries.
- R3: Writing address 3 with bit 31 set starts a command. Busy then reads 1 for exactly DEPTH+1 cycles. Any write to any register while busy is ignored.
- R4: Load (code 2) with a status other than zero overwrites, in place, a valid entry that has the same MAC and VLAN ID. If no such entry exists, it fills the lowest-numbered empty slot.
- R5: A load that finds neither a matching entry nor an empty slot sets full and leaves the table unchanged. Full is cleared when the next command starts.
- R6: Purge (code 3) empties the valid entry whose MAC and VLAN ID match the staged key. If no entry matches, purge has no effect.
- R7: Flush (code 1) empties every slot.
- R8: Next (code 4) returns the valid entry in the lowest slot above the slot that holds the staged key. If the staged MAC and VLAN ID are all zero, it returns the first valid entry.
- R9: A next command that finds no qualifying entry sets all three data words to zero, so the status reads 0.
- R10: Other command codes occupy busy for the normal time and change neither the table nor the data words.
- R11: When the filter enable is set, next considers only entries whose port-mask bit at the filter port index is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write register select |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read register select (combinational read) |
| rd_data | output | 32 | Read data |

## Verification
The assertions assume that software stages the key before it starts a command and then leaves the interface alone until busy drops. Writes made while busy must be shown to have no effect. The stimulus follows this discipline everywhere except one scenario, which deliberately writes a new command and a data word in the middle of a scan. The results are then checked against the untouched key. Loads always carry a nonzero status, because the occupancy check after a successful load relies on that.

// File: rtl/addr_table_engine.sv
module addr_table_engine #(
  parameter int DEPTH = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  wr_addr,
  input  logic [31:0] wr_data,
  input  logic [1:0]  rd_addr,
  output logic [31:0] rd_data
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam logic [3:0] C_FLUSH = 4'd1;
  localparam logic [3:0] C_LOAD  = 4'd2;
  localparam logic [3:0] C_PURGE = 4'd3;
  localparam logic [3:0] C_NEXT  = 4'd4;

  logic [31:0] dw0, dw1, dw2;
  logic        f_busy, f_full, f_fin, f_pen;
  logic [3:0]  f_cmd;
  logic [2:0]  f_port;

  logic [47:0] t_mac [DEPTH];
  logic [11:0] t_vid [DEPTH];
  logic [6:0]  t_pm  [DEPTH];
  logic [3:0]  t_st  [DEPTH];
  logic [DEPTH-1:0] occ;

  logic [IDX_W-1:0] idx, hit_idx, free_idx, res_idx;
  logic hit_v, free_v, res_v, seen;

  for (genvar g = 0; g < DEPTH; g++) begin : g_occ
    assign occ[g] = t_st[g] != 4'd0;
  end

  logic [47:0] k_mac;
  logic [11:0] k_vid;
  logic [6:0]  pm_sh;
  logic        s_valid, s_key, s_pass, last;
  logic [IDX_W-1:0] put_idx;

  assign k_mac   = {dw1[15:0], dw0};
  assign k_vid   = dw2[19:8];
  assign s_valid = occ[idx];
  assign s_key   = s_valid && t_mac[idx] == k_mac && t_vid[idx] == k_vid;
  assign pm_sh   = t_pm[idx] >> f_port;
  assign s_pass  = !f_pen || pm_sh[0];
  assign last    = idx == IDX_W'(DEPTH - 1);
  assign put_idx = hit_v ? hit_idx : free_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dw0 <= '0; dw1 <= '0; dw2 <= '0;
      f_busy <= 1'b0; f_full <= 1'b0; f_fin <= 1'b0; f_pen <= 1'b0;
      f_cmd <= '0; f_port <= '0;
      idx <= '0; hit_idx <= '0; free_idx <= '0; res_idx <= '0;
      hit_v <= 1'b0; free_v <= 1'b0; res_v <= 1'b0; seen <= 1'b0;
      for (int i = 0; i < DEPTH; i++) begin
        t_mac[i] <= '0; t_vid[i] <= '0; t_pm[i] <= '0; t_st[i] <= '0;
      end
    end else if (f_busy && !f_fin) begin
      case (f_cmd)
        C_FLUSH: t_st[idx] <= '0;
        C_PURGE: if (s_key) t_st[idx] <= '0;
        C_LOAD: begin
          if (s_key && !hit_v) begin hit_v <= 1'b1; hit_idx <= idx; end
          if (!s_valid && !free_v) begin free_v <= 1'b1; free_idx <= idx; end
        end
        C_NEXT: begin
          if (!res_v && seen && s_valid && s_pass) begin res_v <= 1'b1; res_idx <= idx; end
          if (s_key) seen <= 1'b1;
        end
        default: ;
      endcase
      if (last) f_fin <= 1'b1;
      else      idx <= idx + 1'b1;
    end else if (f_busy) begin
      f_busy <= 1'b0;
      f_fin  <= 1'b0;
      if (f_cmd == C_LOAD) begin
        if (hit_v || free_v) begin
          t_mac[put_idx] <= k_mac;
          t_vid[put_idx] <= k_vid;
          t_pm[put_idx]  <= dw1[22:16];
          t_st[put_idx]  <= dw2[3:0];
        end else begin
          f_full <= 1'b1;
        end
      end
      if (f_cmd == C_NEXT) begin
        if (res_v) begin
          dw0 <= t_mac[res_idx][31:0];
          dw1 <= {9'd0, t_pm[res_idx], t_mac[res_idx][47:32]};
          dw2 <= {12'd0, t_vid[res_idx], 4'd0, t_st[res_idx]};
        end else begin
          dw0 <= '0; dw1 <= '0; dw2 <= '0;
        end
      end
    end else if (wr_en) begin
      case (wr_addr)
        2'd0: dw0 <= wr_data;
        2'd1: dw1 <= {9'd0, wr_data[22:0]};
        2'd2: dw2 <= {12'd0, wr_data[19:8], 4'd0, wr_data[3:0]};
        default: begin
          f_cmd  <= wr_data[3:0];
          f_port <= wr_data[10:8];
          f_pen  <= wr_data[12];
          f_busy <= wr_data[31];
          if (wr_data[31]) begin
            f_full <= 1'b0;
            idx    <= '0;
            hit_v  <= 1'b0;
            free_v <= 1'b0;
            res_v  <= 1'b0;
            seen   <= (k_mac == 48'd0) && (k_vid == 12'd0);
          end
        end
      endcase
    end
  end

  always_comb begin
    case (rd_addr)
      2'd0:    rd_data = dw0;
      2'd1:    rd_data = dw1;
      2'd2:    rd_data = dw2;
      default: rd_data = {f_busy, f_full, 17'd0, f_pen, 1'b0, f_port, 4'd0, f_cmd};
    endcase
  end
endmodule

// File: rtl/addr_table_engine_sva.sv
module addr_table_engine_sva #(
  parameter int DEPTH = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             full,
  input logic [3:0]       cmd,
  input logic [31:0]      w0,
  input logic [31:0]      w1,
  input logic [31:0]      w2,
  input logic [DEPTH-1:0] occ
);
  localparam int CW = $clog2(DEPTH + 2) + 1;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt <= '0;
    else if (!busy) cnt <= '0;
    else            cnt <= cnt + 1'b1;
  end

  assert_busy_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> cnt == CW'(DEPTH + 1));

  assert_busy_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> cnt <= CW'(DEPTH));

  assert_stage_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt < CW'(DEPTH)) |=> ($stable(w0) && $stable(w1) && $stable(w2)));

  assert_full_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(full) |-> cmd == 4'd2);

  assert_full_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !full);

  assert_load_placed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && cmd == 4'd2 && !full && w2[3:0] != 4'd0) |-> occ != '0);

  assert_flush_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && cmd == 4'd1) |-> occ == '0);

  assert_next_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && cmd == 4'd4 && w2[3:0] == 4'd0) |-> (w0 == 32'd0 && w1 == 32'd0 && w2 == 32'd0));
endmodule

bind addr_table_engine addr_table_engine_sva #(.DEPTH(DEPTH)) u_sva (
  .clk(clk), .rst_n(rst_n), .busy(f_busy), .full(f_full), .cmd(f_cmd),
  .w0(dw0), .w1(dw1), .w2(dw2), .occ(occ)
);

// File: tb/addr_table_engine_bench.sv
`timescale 1ns/1ps
module addr_table_engine_bench;
  localparam int DEPTH = 16;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [1:0] wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0, rd_data;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  addr_table_engine #(.DEPTH(DEPTH)) u_addr_table_engine (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data));

  localparam logic [47:0] MAC_A = 48'h0011_2233_4455;
  localparam logic [47:0] MAC_B = 48'h0A0B_0C0D_0E0F;
  localparam logic [47:0] MAC_C = 48'h00C0_FFEE_0001;

  function automatic logic [47:0] kmac(int i);
    return 48'h0200_0000_0100 | 48'(i);
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    rd_addr = a; #1; v = rd_data;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic wait_done(output int n);
    logic [31:0] v;
    n = 0; rd(2'd3, v);
    while (v[31] && n < 1000) begin n++; @(negedge clk); rd(2'd3, v); end
  endtask

  task automatic run(input logic [31:0] func, output int n);
    wr(2'd3, func); wait_done(n);
  endtask

  task automatic stage(logic [47:0] mac, logic [11:0] vid, logic [6:0] pm, logic [3:0] st);
    wr(2'd0, mac[31:0]);
    wr(2'd1, {9'd0, pm, mac[47:32]});
    wr(2'd2, {12'd0, vid, 4'd0, st});
  endtask

  task automatic expect_entry(string tag, logic [47:0] mac, logic [11:0] vid, logic [6:0] pm, logic [3:0] st);
    logic [31:0] v;
    rd(2'd0, v); check({tag, " word0"}, v, mac[31:0]);
    rd(2'd1, v); check({tag, " word1"}, v, {9'd0, pm, mac[47:32]});
    rd(2'd2, v); check({tag, " word2"}, v, {12'd0, vid, 4'd0, st});
  endtask

  task automatic do_load(logic [47:0] mac, logic [11:0] vid, logic [6:0] pm, logic [3:0] st);
    int n;
    stage(mac, vid, pm, st); run(32'h8000_0002, n);
  endtask

  task automatic do_next(logic [47:0] mac, logic [11:0] vid, logic [31:0] func);
    int n;
    stage(mac, vid, 7'd0, 4'd0); run(func, n);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v); check("R1 reset register", v, 32'd0);
    end
    do_next(48'd0, 12'd0, 32'h8000_0004);
    expect_entry("R1 R9 empty table next", 48'd0, 12'd0, 7'd0, 4'd0);
  endtask

  task automatic t_load_next;
    int n;
    logic [31:0] v;
    stage(MAC_A, 12'd5, 7'h02, 4'd15);
    run(32'h8000_0002, n);
    check("R3 busy cycles", 32'(n), 32'(DEPTH + 1));
    rd(2'd3, v); check("R2 function readback", v, 32'h0000_0002);
    do_load(MAC_B, 12'd7, 7'h04, 4'd3);
    do_next(48'd0, 12'd0, 32'h8000_0004);
    expect_entry("R8 R2 first entry", MAC_A, 12'd5, 7'h02, 4'd15);
    do_next(MAC_A, 12'd5, 32'h8000_0004);
    expect_entry("R8 follow A", MAC_B, 12'd7, 7'h04, 4'd3);
    do_next(MAC_B, 12'd7, 32'h8000_0004);
    expect_entry("R9 past last", 48'd0, 12'd0, 7'd0, 4'd0);
  endtask

  task automatic t_overwrite;
    do_load(MAC_A, 12'd5, 7'h08, 4'd2);
    do_next(48'd0, 12'd0, 32'h8000_0004);
    expect_entry("R4 overwrite in place", MAC_A, 12'd5, 7'h08, 4'd2);
  endtask

  task automatic t_filter;
    do_next(48'd0, 12'd0, 32'h8000_1204);
    expect_entry("R11 filter port2", MAC_B, 12'd7, 7'h04, 4'd3);
    do_next(48'd0, 12'd0, 32'h8000_1304);
    expect_entry("R11 filter port3", MAC_A, 12'd5, 7'h08, 4'd2);
    do_next(MAC_A, 12'd5, 32'h8000_1304);
    expect_entry("R11 R9 filter exhausted", 48'd0, 12'd0, 7'd0, 4'd0);
  endtask

  task automatic t_purge;
    int n;
    stage(MAC_A, 12'd5, 7'd0, 4'd0); run(32'h8000_0003, n);
    do_next(48'd0, 12'd0, 32'h8000_0004);
    expect_entry("R6 purge A", MAC_B, 12'd7, 7'h04, 4'd3);
    stage(MAC_C, 12'd9, 7'd0, 4'd0); run(32'h8000_0003, n);
    do_next(48'd0, 12'd0, 32'h8000_0004);
    expect_entry("R6 purge miss", MAC_B, 12'd7, 7'h04, 4'd3);
    do_load(MAC_C, 12'd9, 7'h01, 4'd1);
    do_next(48'd0, 12'd0, 32'h8000_0004);
    expect_entry("R4 lowest free slot", MAC_C, 12'd9, 7'h01, 4'd1);
  endtask

  task automatic t_full;
    int n;
    logic [31:0] v;
    run(32'h8000_0001, n);
    for (int i = 0; i < DEPTH; i++) do_load(kmac(i), 12'd10, 7'h01, 4'd15);
    do_load(kmac(DEPTH), 12'd10, 7'h01, 4'd15);
    rd(2'd3, v); check("R5 full set", v, 32'h4000_0002);
    do_next(kmac(DEPTH - 2), 12'd10, 32'h8000_0004);
    expect_entry("R5 table unchanged tail", kmac(DEPTH - 1), 12'd10, 7'h01, 4'd15);
    do_next(kmac(DEPTH - 1), 12'd10, 32'h8000_0004);
    expect_entry("R5 no extra slot", 48'd0, 12'd0, 7'd0, 4'd0);
    rd(2'd3, v); check("R5 full cleared", v, 32'h0000_0004);
    do_load(kmac(3), 12'd10, 7'h10, 4'd15);
    rd(2'd3, v); check("R4 update when full", v, 32'h0000_0002);
    do_next(kmac(2), 12'd10, 32'h8000_0004);
    expect_entry("R4 updated entry", kmac(3), 12'd10, 7'h10, 4'd15);
  endtask

  task automatic t_ignore;
    int n;
    logic [31:0] v;
    stage(48'd0, 12'd0, 7'd0, 4'd0);
    wr(2'd3, 32'h8000_0004);
    wr(2'd3, 32'h8000_0001);
    wr(2'd0, 32'hDEAD_BEEF);
    wait_done(n);
    expect_entry("R3 ignored writes result", kmac(0), 12'd10, 7'h01, 4'd15);
    rd(2'd3, v); check("R3 function kept", v, 32'h0000_0004);
    wr(2'd3, 32'h8000_0007);
    wait_done(n);
    check("R10 unknown busy cycles", 32'(n), 32'(DEPTH + 1));
    expect_entry("R10 words unchanged", kmac(0), 12'd10, 7'h01, 4'd15);
    do_next(48'd0, 12'd0, 32'h8000_0004);
    expect_entry("R10 table intact", kmac(0), 12'd10, 7'h01, 4'd15);
  endtask

  task automatic t_flush;
    int n;
    run(32'h8000_0001, n);
    do_next(48'd0, 12'd0, 32'h8000_0004);
    expect_entry("R7 flushed", 48'd0, 12'd0, 7'd0, 4'd0);
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_load_next;
    t_overwrite;
    t_filter;
    t_purge;
    t_full;
    t_ignore;
    t_flush;
    finish_run;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R3 watchdog: actual running expected finished");
    finish_run;
  end
endmodule